// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block decides which clocks of a small microcontroller core are alive. Software selects one of two low-power states by writing a two-bit request register. In the light state (idle) only the CPU clock is gated; timers, serial logic, interrupt logic and RAM keep their clock and every register keeps its value. In the deep state (power-down) the oscillator enable is dropped, so nothing is clocked after the instruction that made the request.

Idle ends when the interrupt controller reports any enabled pending interrupt. Power-down ends either on a hardware reset or on an external interrupt pin that is enabled and set to level mode: while such a pin is held low the oscillator restarts, and the CPU clocks stay gated until the oscillator is settled (a stable flag from the analog side or a programmable number of oscillator cycles, whichever comes first) and the pin has gone high again. A reset pin only takes effect after it has been held high for two machine cycles of running clock. The block also reports its state on a mode output and tells the pad logic to hold the address-latch and program-strobe pins high in idle and low in power-down.

States: RUN, IDLE, PDOWN, WAKE_INT (oscillator restarting after an interrupt pin), WAIT_RISE (settled, waiting for the pin to go high), WAKE_RST (oscillator restarting for a reset). Transitions: RUN to PDOWN on the power-down bit, RUN to IDLE on the idle bit alone, IDLE to RUN on a pending interrupt, PDOWN to WAKE_RST on the reset pin, PDOWN to WAKE_INT on a qualified low pin, WAKE_INT to WAIT_RISE when settled with the pin still low, WAKE_INT to RUN when settled with the pin high, WAIT_RISE to RUN when the pin goes high, WAKE_RST to RUN when settled, and any state to RUN when the filtered core reset fires.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After rst_n, mode is 00 (run), cpu_clk_en, per_clk_en and osc_en are 1, ctl_q is 00, pin_force and core_rst are 0.
- R2: ctl_q bit 0 is the idle request and bit 1 the power-down request; a ctl_wr pulse loads ctl_wdata at the next edge only while the mode is run, and is ignored in every other mode; the state changes one edge after the bit appears on ctl_q.
- R3: In idle (mode 01) cpu_clk_en is 0 while per_clk_en and osc_en are 1, and pin_force=1 with pin_lvl=1.
- R4: Idle ends at the first edge where irq_pending is 1; an external pin going low without irq_pending leaves idle unchanged.
- R5: With bit 1 set (alone or together with bit 0) the block enters power-down (mode 10): all three enables are 0, pin_force=1 and pin_lvl=0.
- R6: In power-down, irq_pending, pins with ext_int_en=0 and pins with ext_int_lvl=0 (edge mode) have no effect; the mode stays 10 and osc_en stays 0.
- R7: A pin with ext_int_en=1, ext_int_lvl=1 and ext_int_n=0 moves power-down to the wake mode (11) at the next edge: osc_en=1, cpu_clk_en=0, per_clk_en=0; with osc_stable low, the oscillator counts as settled after wake_cycles+1 edges in the wake state.
- R8: An interrupt wake returns to run at edge max(L,P)+1 after entering the wake state, where L is wake_cycles and P is the number of edges the pin stayed low after entry; clocks stay gated until then.
- R9: osc_stable=1 during a wake settles the oscillator at once, so the next edge leaves the wake state regardless of wake_cycles.
- R10: core_rst rises after hw_rst has been high on 2*MC_CLKS consecutive edges in run or idle; a shorter pulse has no effect; one edge after core_rst the mode is run and ctl_q is 00.
- R11: hw_rst high in power-down restarts the oscillator (mode 11, osc_en=1), returns to run once settled, and then core_rst follows after the 2*MC_CLKS hold.
- R12: ctl_q reads 00 on every return to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ctl_wr | input | 1 | Write strobe for the request register |
| ctl_wdata | input | 2 | Request bits: bit 0 idle, bit 1 power-down |
| ctl_q | output | 2 | Request register contents |
| irq_pending | input | 1 | Any enabled interrupt is pending |
| ext_int_n | input | NUM_EXT | External interrupt pin levels, active low |
| ext_int_en | input | NUM_EXT | Per-pin interrupt enable |
| ext_int_lvl | input | NUM_EXT | Per-pin trigger type, 1 = level |
| hw_rst | input | 1 | Reset pin level, active high |
| osc_stable | input | 1 | Oscillator stable flag from the analog side |
| wake_cycles | input | CNT_W | Settle count in oscillator cycles |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| mode | output | 2 | 00 run, 01 idle, 10 power-down, 11 waking |
| pin_force | output | 1 | Pad logic holds the strobe pins static |
| pin_lvl | output | 1 | Static level for the strobe pins |
| core_rst | output | 1 | Filtered reset to the core registers |

## Verification
The bench builds the block with MC_CLKS=4 and CNT_W=8, so the reset hold is 8 edges and the settle count stays below 16 in the random part; short-pulse rejection, reset from power-down and many wake sequences therefore fit in a few thousand cycles. Random wake trials draw the settle count and the pin hold time independently, which lands on both sides of the point where the pin returns high before or after the oscillator settles, and the edge-exact exit cycle is checked against max(L,P)+1. Directed cases cover wake_cycles of zero, the stable-flag shortcut with a large count, disabled and edge-mode pins, and writes made outside run.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_PDOWN,
        ST_WAKE_INT,
        ST_WAIT_RISE,
        ST_WAKE_RST
    } pmc_state_e;

    localparam logic [1:0] MODE_RUN   = 2'b00;
    localparam logic [1:0] MODE_IDLE  = 2'b01;
    localparam logic [1:0] MODE_PDOWN = 2'b10;
    localparam logic [1:0] MODE_WAKE  = 2'b11;

    localparam int REQ_IDLE_BIT = 0;
    localparam int REQ_PD_BIT   = 1;

    typedef struct packed {
        logic       cpu_clk_en;
        logic       per_clk_en;
        logic       osc_en;
        logic [1:0] mode;
        logic       pin_force;
        logic       pin_lvl;
    } pmc_out_t;

endpackage

// File: rtl/pmc_req_reg.sv
module pmc_req_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    input  logic       clr,
    output logic [1:0] req_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 2'b00;
        end else if (clr) begin
            req_q <= 2'b00;
        end else if (wr_en) begin
            req_q <= wr_data;
        end
    end

    AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (req_q == 2'b00)); // R12

endmodule

// File: rtl/pmc_rst_filter.sv
module pmc_rst_filter #(
    parameter int MC_CLKS = 12,
    parameter int RST_MC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic count_en,
    output logic fire
);

    localparam int HOLD = MC_CLKS * RST_MC;
    localparam int CW   = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (pin && count_en) begin
            if (cnt != HOLD_V) begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

    assign fire = (cnt == HOLD_V);

    AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(pin)); // R10

endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    input  logic             osc_stable,
    output logic             settled
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt < limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign settled = run && (osc_stable || (cnt >= limit));

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_q,
    input  logic       irq_any,
    input  logic       wake_low,
    input  logic       rst_pin,
    input  logic       core_rst,
    input  logic       settled,
    output pmc_state_e state,
    output logic       exit_run,
    output pmc_out_t   outs
);

    pmc_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        if (core_rst) begin
            nxt = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (req_q[REQ_PD_BIT]) begin
                        nxt = ST_PDOWN;
                    end else if (req_q[REQ_IDLE_BIT]) begin
                        nxt = ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (irq_any) begin
                        nxt = ST_RUN;
                    end
                end
                ST_PDOWN: begin
                    if (rst_pin) begin
                        nxt = ST_WAKE_RST;
                    end else if (wake_low) begin
                        nxt = ST_WAKE_INT;
                    end
                end
                ST_WAKE_INT: begin
                    if (settled) begin
                        nxt = wake_low ? ST_WAIT_RISE : ST_RUN;
                    end
                end
                ST_WAIT_RISE: begin
                    if (!wake_low) begin
                        nxt = ST_RUN;
                    end
                end
                ST_WAKE_RST: begin
                    if (settled) begin
                        nxt = ST_RUN;
                    end
                end
                default: nxt = ST_RUN;
            endcase
        end
    end

    assign exit_run = core_rst || ((state != ST_RUN) && (nxt == ST_RUN));

    always_comb begin
        outs = '{cpu_clk_en: 1'b1, per_clk_en: 1'b1, osc_en: 1'b1,
                 mode: MODE_RUN, pin_force: 1'b0, pin_lvl: 1'b0};
        unique case (state)
            ST_RUN: begin
                outs.mode = MODE_RUN;
            end
            ST_IDLE: begin
                outs.cpu_clk_en = 1'b0;
                outs.mode       = MODE_IDLE;
                outs.pin_force  = 1'b1;
                outs.pin_lvl    = 1'b1;
            end
            ST_PDOWN: begin
                outs.cpu_clk_en = 1'b0;
                outs.per_clk_en = 1'b0;
                outs.osc_en     = 1'b0;
                outs.mode       = MODE_PDOWN;
                outs.pin_force  = 1'b1;
            end
            ST_WAKE_INT, ST_WAIT_RISE, ST_WAKE_RST: begin
                outs.cpu_clk_en = 1'b0;
                outs.per_clk_en = 1'b0;
                outs.mode       = MODE_WAKE;
                outs.pin_force  = 1'b1;
            end
            default: begin
                outs.mode = MODE_RUN;
            end
        endcase
    end

    AST_PD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && req_q == 2'b11 && !core_rst) |=> (state == ST_PDOWN)); // R5
    AST_PD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PDOWN && !rst_pin && !wake_low && !core_rst) |=> (state == ST_PDOWN)); // R6
    AST_RISE_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RISE && wake_low && !core_rst) |=> (state == ST_WAIT_RISE)); // R8

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NUM_EXT = 2,
    parameter int MC_CLKS = 12,
    parameter int RST_MC  = 2,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [1:0]         ctl_wdata,
    output logic [1:0]         ctl_q,
    input  logic               irq_pending,
    input  logic [NUM_EXT-1:0] ext_int_n,
    input  logic [NUM_EXT-1:0] ext_int_en,
    input  logic [NUM_EXT-1:0] ext_int_lvl,
    input  logic               hw_rst,
    input  logic               osc_stable,
    input  logic [CNT_W-1:0]   wake_cycles,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               osc_en,
    output logic [1:0]         mode,
    output logic               pin_force,
    output logic               pin_lvl,
    output logic               core_rst
);

    pmc_state_e         state;
    pmc_out_t           outs;
    logic               exit_run;
    logic               settled;
    logic               clocks_live;
    logic               timer_run;
    logic [NUM_EXT-1:0] pin_hit;
    logic               wake_low;

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_pin
        assign pin_hit[g] = ext_int_en[g] & ext_int_lvl[g] & ~ext_int_n[g];
    end
    assign wake_low = |pin_hit;

    assign clocks_live = (state == ST_RUN) || (state == ST_IDLE);
    assign timer_run   = (state == ST_WAKE_INT) || (state == ST_WAKE_RST);

    pmc_req_reg u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr && (state == ST_RUN)),
        .wr_data (ctl_wdata),
        .clr     (exit_run),
        .req_q   (ctl_q)
    );

    pmc_rst_filter #(
        .MC_CLKS (MC_CLKS),
        .RST_MC  (RST_MC)
    ) u_rstf (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (hw_rst),
        .count_en (clocks_live),
        .fire     (core_rst)
    );

    pmc_settle_timer #(
        .CNT_W (CNT_W)
    ) u_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (timer_run),
        .limit      (wake_cycles),
        .osc_stable (osc_stable),
        .settled    (settled)
    );

    pmc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_q    (ctl_q),
        .irq_any  (irq_pending),
        .wake_low (wake_low),
        .rst_pin  (hw_rst),
        .core_rst (core_rst),
        .settled  (settled),
        .state    (state),
        .exit_run (exit_run),
        .outs     (outs)
    );

    assign cpu_clk_en = outs.cpu_clk_en;
    assign per_clk_en = outs.per_clk_en;
    assign osc_en     = outs.osc_en;
    assign mode       = outs.mode;
    assign pin_force  = outs.pin_force;
    assign pin_lvl    = outs.pin_lvl;

    AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE) |-> (!cpu_clk_en && per_clk_en && osc_en && pin_lvl)); // R3
    AST_PD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PDOWN) |-> (!osc_en && !per_clk_en && !cpu_clk_en && !pin_lvl)); // R5
    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WAKE) |-> (osc_en && !cpu_clk_en)); // R7
    AST_RST_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> (mode == MODE_RUN && ctl_q == 2'b00)); // R10
    AST_RUN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && $past(mode) != MODE_RUN) |-> (ctl_q == 2'b00)); // R12

endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

    localparam int NUM_EXT = 2;
    localparam int MC_CLKS = 4;
    localparam int RST_MC  = 2;
    localparam int CNT_W   = 8;
    localparam int HOLD    = MC_CLKS * RST_MC;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ctl_wr = 1'b0;
    logic [1:0]         ctl_wdata = 2'b00;
    logic [1:0]         ctl_q;
    logic               irq_pending = 1'b0;
    logic [NUM_EXT-1:0] ext_int_n = '1;
    logic [NUM_EXT-1:0] ext_int_en = 2'b11;
    logic [NUM_EXT-1:0] ext_int_lvl = 2'b01;
    logic               hw_rst = 1'b0;
    logic               osc_stable = 1'b0;
    logic [CNT_W-1:0]   wake_cycles = '0;
    logic               cpu_clk_en, per_clk_en, osc_en, pin_force, pin_lvl, core_rst;
    logic [1:0]         mode;

    int vec_cnt = 0;
    int err_cnt = 0;
    int seed_val;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(
        .NUM_EXT (NUM_EXT),
        .MC_CLKS (MC_CLKS),
        .RST_MC  (RST_MC),
        .CNT_W   (CNT_W)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .ctl_q       (ctl_q),
        .irq_pending (irq_pending),
        .ext_int_n   (ext_int_n),
        .ext_int_en  (ext_int_en),
        .ext_int_lvl (ext_int_lvl),
        .hw_rst      (hw_rst),
        .osc_stable  (osc_stable),
        .wake_cycles (wake_cycles),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .osc_en      (osc_en),
        .mode        (mode),
        .pin_force   (pin_force),
        .pin_lvl     (pin_lvl),
        .core_rst    (core_rst)
    );

    // {cpu, per, osc} expected for a mode code
    function automatic logic [2:0] exp_clk(input logic [1:0] m);
        case (m)
            2'b00:   return 3'b111;
            2'b01:   return 3'b011;
            2'b10:   return 3'b000;
            default: return 3'b001;
        endcase
    endfunction

    // {pin_force, pin_lvl} expected for a mode code
    function automatic logic [1:0] exp_pin(input logic [1:0] m);
        case (m)
            2'b00:   return 2'b00;
            2'b01:   return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic int exp_exit(input int l, input int p);
        return ((l > p) ? l : p) + 1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_mode(input string tag, input logic [1:0] m);
        chk({tag, " mode"}, 32'(mode), 32'(m));
        chk({tag, " clocks"}, 32'({cpu_clk_en, per_clk_en, osc_en}), 32'(exp_clk(m)));
        chk({tag, " pins"}, 32'({pin_force, pin_lvl}), 32'(exp_pin(m)));
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_req(input logic [1:0] v);
        ctl_wr    = 1'b1;
        ctl_wdata = v;
        step(1);
        ctl_wr    = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        err_cnt++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        seed_val = $urandom(32'h5eed_0042);
        step(2);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk_mode("R1 reset", 2'b00);
        chk("R1 ctl_q", 32'(ctl_q), 0);
        chk("R1 core_rst", 32'(core_rst), 0);

        // R2 / R3 idle entry
        write_req(2'b01);
        chk("R2 ctl_q after write", 32'(ctl_q), 32'h1);
        chk_mode("R2 still run", 2'b00);
        step(1);
        chk_mode("R3 idle", 2'b01);

        // R2 write ignored outside run
        write_req(2'b10);
        chk("R2 write in idle ignored", 32'(ctl_q), 32'h1);
        chk_mode("R2 idle kept", 2'b01);

        // R4 pin alone does not end idle
        ext_int_n = 2'b10;
        step(3);
        chk_mode("R4 pin no exit", 2'b01);
        ext_int_n = 2'b11;
        irq_pending = 1'b1;
        step(1);
        irq_pending = 1'b0;
        chk_mode("R4 irq exit", 2'b00);
        chk("R12 ctl cleared after idle", 32'(ctl_q), 0);

        // R5 both bits -> power-down
        write_req(2'b11);
        step(1);
        chk_mode("R5 pd priority", 2'b10);

        // R6 ignored stimuli
        irq_pending = 1'b1;
        step(2);
        chk_mode("R6 irq ignored", 2'b10);
        irq_pending = 1'b0;
        ext_int_n = 2'b01;
        step(2);
        chk_mode("R6 edge pin ignored", 2'b10);
        ext_int_n = 2'b11;
        ext_int_en = 2'b10;
        ext_int_lvl = 2'b11;
        ext_int_n = 2'b10;
        step(2);
        chk_mode("R6 disabled pin ignored", 2'b10);
        ext_int_n = 2'b11;
        ext_int_en = 2'b11;
        ext_int_lvl = 2'b01;
        step(1);

        // R7 / R8 wake with wake_cycles=0, pin released at once
        wake_cycles = 8'd0;
        ext_int_n = 2'b10;
        step(1);
        chk_mode("R7 wake entered", 2'b11);
        ext_int_n = 2'b11;
        step(1);
        chk_mode("R8 exit L=0", 2'b00);
        chk("R12 ctl cleared after pd", 32'(ctl_q), 0);

        // R7 / R8 pin held beyond settle
        write_req(2'b10);
        step(1);
        wake_cycles = 8'd3;
        ext_int_n = 2'b10;
        step(1);
        step(5);
        chk_mode("R8 waiting for rise", 2'b11);
        ext_int_n = 2'b11;
        step(1);
        chk_mode("R8 exit after rise", 2'b00);

        // R9 stable flag shortcut
        write_req(2'b10);
        step(1);
        wake_cycles = 8'd200;
        ext_int_n = 2'b10;
        step(1);
        ext_int_n = 2'b11;
        step(3);
        chk_mode("R9 still settling", 2'b11);
        osc_stable = 1'b1;
        step(1);
        chk_mode("R9 stable exit", 2'b00);
        osc_stable = 1'b0;

        // R10 short pulse rejected
        hw_rst = 1'b1;
        step(HOLD - 1);
        chk("R10 short pulse", 32'(core_rst), 0);
        hw_rst = 1'b0;
        step(2);
        chk("R10 no reset after short", 32'(core_rst), 0);

        // R10 reset from idle
        write_req(2'b01);
        step(1);
        hw_rst = 1'b1;
        step(HOLD - 1);
        chk("R10 before hold", 32'(core_rst), 0);
        step(1);
        chk("R10 fire", 32'(core_rst), 1);
        step(1);
        chk_mode("R10 back to run", 2'b00);
        chk("R10 ctl cleared", 32'(ctl_q), 0);
        hw_rst = 1'b0;
        step(1);
        chk("R10 release", 32'(core_rst), 0);

        // R11 reset from power-down
        write_req(2'b10);
        step(1);
        wake_cycles = 8'd4;
        hw_rst = 1'b1;
        step(1);
        chk_mode("R11 osc restart", 2'b11);
        step(4);
        chk_mode("R11 still settling", 2'b11);
        step(1);
        chk_mode("R11 run", 2'b00);
        step(HOLD - 1);
        chk("R11 before hold", 32'(core_rst), 0);
        step(1);
        chk("R11 fire", 32'(core_rst), 1);
        hw_rst = 1'b0;
        step(1);

        // Random idle and power-down trials
        for (int it = 0; it < 60; it++) begin
            if ($urandom_range(0, 2) == 0) begin
                int r;
                r = $urandom_range(0, 7);
                write_req(2'b01);
                step(1);
                step(r);
                chk_mode("R4 random idle hold", 2'b01);
                irq_pending = 1'b1;
                step(1);
                irq_pending = 1'b0;
                chk_mode("R4 random idle exit", 2'b00);
            end else begin
                int l;
                int p;
                int n;
                int ok;
                l = $urandom_range(0, 15);
                p = $urandom_range(0, 20);
                wake_cycles = 8'(l);
                write_req(($urandom_range(0, 1) == 1) ? 2'b11 : 2'b10);
                step(1);
                chk_mode("R5 random pd", 2'b10);
                ext_int_n = 2'b10;
                step(1);
                n = 0;
                ok = 1;
                while (mode != 2'b00 && n < 100) begin
                    if (cpu_clk_en !== 1'b0) ok = 0;
                    if (n == p) ext_int_n = 2'b11;
                    step(1);
                    n++;
                end
                ext_int_n = 2'b11;
                chk("R8 random exit edge", 32'(n), 32'(exp_exit(l, p)));
                chk("R7 random gated", 32'(ok), 1);
                chk("R12 random ctl", 32'(ctl_q), 0);
            end
        end

        finish_run();
    end

endmodule